// File: doc/BRIEF.md
# Tiled Surface Address Generator

This unit turns a pixel coordinate into the byte offset of that pixel inside a surface held in memory. The surface is described by four values: its pitch in pixels, its bytes per pixel, its layout and its address swizzle mode. The layout is one of three:

- a plain row-by-row linear layout;
- 4 KB tiles that are wide and short;
- 4 KB tiles that are narrow and tall, with the bytes inside each tile stored in 16-byte columns.

For the tiled layouts, an optional swizzle can flip bit 6 of the offset inside the tile. Bit 6 is XORed with a chosen set of bits 9, 10 and 11 of the same in-tile offset. Only after that is the tile's base added.

The unit does not touch memory. It does no caching, no format conversion and no clipping. A span engine or copy engine sits in front of it, presents one coordinate per cycle with a valid strobe, and receives the offset one cycle later. The register stage can be removed with a parameter, in which case the result appears in the same cycle. If the layout or swizzle code is undefined, the unit raises an error flag and returns a zero offset.

Top module: `tag_addr_gen`

## Requirements
- R1: With layout code 0 (linear) the offset equals (y*pitch + x)*bpp.
- R2: With layout code 1 (wide tiles, 512 bytes by 8 rows) and swizzle code 0, the in-tile offset equals (y mod 8)*512 + (x*bpp mod 512).
- R3: With layout code 2 (tall tiles, 128 bytes by 32 rows) and swizzle code 0, the in-tile offset equals ((x*bpp mod 128) div 16)*512 + (y mod 32)*16 + (x*bpp mod 16).
- R4: For both tiled layouts the offset is the in-tile offset plus a tile base. The base is (x*bpp div W)*4096 + (y div H)*pitch*bpp*H. W is 512 and H is 8 for wide tiles; W is 128 and H is 32 for tall tiles.
- R5: Swizzle codes act on the in-tile offset before the base is added, by replacing bit 6 with an XOR. Code 0 leaves it unchanged. Code 1 XORs in bit 9. Code 2 XORs in bits 9 and 10. Code 3 XORs in bits 9 and 11. Code 4 XORs in bits 9, 10 and 11. No other bit of the offset changes.
- R6: In linear layout a defined swizzle code (0 to 4) has no effect on the offset and raises no error.
- R7: Layout code 3, or swizzle codes 5 to 7, set the error output to 1 and the offset to 0, in every layout.
- R8: With the register stage enabled, the offset and error for an input presented with in_valid are on the outputs, with out_valid high, on the following cycle. out_valid is low in the cycle after an idle input. After reset, out_valid, err and offset are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Coordinate presented this cycle |
| x_in | input | 16 | Pixel column |
| y_in | input | 16 | Pixel row |
| pitch_in | input | 16 | Surface pitch in pixels |
| bpp_in | input | 3 | Bytes per pixel |
| layout_in | input | 2 | 0 linear, 1 wide tiles, 2 tall tiles, 3 undefined |
| swz_in | input | 3 | Swizzle code 0 to 4; 5 to 7 undefined |
| out_valid | output | 1 | Result valid |
| offset_out | output | 32 | Byte offset within the surface |
| err_out | output | 1 | Undefined layout or swizzle code |

## Verification
The assertions assume the following about the inputs: pitch*bpp*32 fits in 32 bits, and the product of coordinate, pitch and bytes per pixel does not overflow the offset. The bit-6 check also assumes the swizzle stage sees only the 12-bit in-tile offset. The stimulus uses a 320-pixel pitch, bytes per pixel of 1, 2 and 4, and coordinates of a few hundred at most, so every offset stays far below 2^32. The sweep covers every layout and swizzle code, including the undefined ones. It also steps coordinates across several tile columns and tile rows, so that the base term is exercised and not only the in-tile term.

// File: rtl/tag_pkg.sv
// Package: shared encodings and tile constants for the address generator.
// Assumes: tiles are always 4 KB; only the geometry inside differs.
package tag_pkg;
    localparam int TILE_LOG2 = 12;                 // 4 KB tile
    localparam logic [1:0] LAYOUT_LINEAR = 2'd0;
    localparam logic [1:0] LAYOUT_WIDE   = 2'd1;
    localparam logic [1:0] LAYOUT_TALL   = 2'd2;

    typedef enum logic [2:0] {
        SWZ_NONE    = 3'd0,
        SWZ_B9      = 3'd1,
        SWZ_B9_10   = 3'd2,
        SWZ_B9_11   = 3'd3,
        SWZ_B9_10_11 = 3'd4
    } swz_mode_e;
endpackage

// File: rtl/tag_linear.sv
// Module: linear layout offset, (y*pitch + x)*bpp.
// Assumes: the product fits in OFS_W bits; wraps silently otherwise.
module tag_linear #(
    parameter int X_W     = 16,
    parameter int Y_W     = 16,
    parameter int PITCH_W = 16,
    parameter int BPP_W   = 3,
    parameter int OFS_W   = 32
) (
    input  logic [X_W-1:0]     x_i,
    input  logic [Y_W-1:0]     y_i,
    input  logic [PITCH_W-1:0] pitch_i,
    input  logic [BPP_W-1:0]   bpp_i,
    output logic [OFS_W-1:0]   ofs_o
);
    logic [OFS_W-1:0] pix_idx;

    // Pixel index then scale to bytes.
    always_comb begin
        pix_idx = OFS_W'(y_i) * OFS_W'(pitch_i) + OFS_W'(x_i);
        ofs_o   = pix_idx * OFS_W'(bpp_i);
    end
endmodule

// File: rtl/tag_tile_geom.sv
// Module: in-tile offset and tile base for one tile geometry.
// IS_TALL=0: 512-byte by 8-row tiles, row-major inside.
// IS_TALL=1: 128-byte by 32-row tiles, stored as 16-byte columns.
// Assumes: Y_W >= 5 and the tile row stride fits in OFS_W bits.
module tag_tile_geom #(
    parameter int X_W     = 16,
    parameter int Y_W     = 16,
    parameter int PITCH_W = 16,
    parameter int BPP_W   = 3,
    parameter int OFS_W   = 32,
    parameter bit IS_TALL = 1'b0
) (
    input  logic [X_W-1:0]     x_i,
    input  logic [Y_W-1:0]     y_i,
    input  logic [PITCH_W-1:0] pitch_i,
    input  logic [BPP_W-1:0]   bpp_i,
    output logic [tag_pkg::TILE_LOG2-1:0] intile_o,
    output logic [OFS_W-1:0]   base_o
);
    localparam int COL_LOG2 = IS_TALL ? 7 : 9;   // tile width in bytes, log2
    localparam int ROW_LOG2 = IS_TALL ? 5 : 3;   // tile height in rows, log2

    logic [OFS_W-1:0]    xbyte;
    logic [COL_LOG2-1:0] col;
    logic [ROW_LOG2-1:0] row;
    logic [OFS_W-1:0]    htile, vtile, stride;

    // Split the byte column and row into tile index and position in tile.
    always_comb begin
        xbyte  = OFS_W'(x_i) * OFS_W'(bpp_i);
        col    = xbyte[COL_LOG2-1:0];
        row    = y_i[ROW_LOG2-1:0];
        htile  = xbyte >> COL_LOG2;
        vtile  = OFS_W'(y_i >> ROW_LOG2);
        stride = (OFS_W'(pitch_i) * OFS_W'(bpp_i)) << ROW_LOG2;
        base_o = (htile << tag_pkg::TILE_LOG2) + vtile * stride;
    end

    generate
        if (IS_TALL) begin : g_tall
            // 16-byte column index on top, then row, then byte in column.
            always_comb intile_o = {col[6:4], row, col[3:0]};
        end else begin : g_wide
            // Row on top, byte column below.
            always_comb intile_o = {row, col};
        end
    endgenerate
endmodule

// File: rtl/tag_swizzle.sv
// Module: bit-6 XOR swizzle on a 12-bit in-tile offset.
// Assumes: the input is the in-tile offset only, before the base is added.
module tag_swizzle (
    input  logic [tag_pkg::TILE_LOG2-1:0] ofs_i,
    input  logic [2:0]                    mode_i,
    output logic [tag_pkg::TILE_LOG2-1:0] ofs_o,
    output logic                          bad_o
);
    import tag_pkg::*;
    logic flip;

    // Select which upper bits fold into bit 6; flag undefined codes.
    always_comb begin
        bad_o = 1'b0;
        unique case (mode_i)
            SWZ_NONE:     flip = 1'b0;
            SWZ_B9:       flip = ofs_i[9];
            SWZ_B9_10:    flip = ofs_i[9] ^ ofs_i[10];
            SWZ_B9_11:    flip = ofs_i[9] ^ ofs_i[11];
            SWZ_B9_10_11: flip = ofs_i[9] ^ ofs_i[10] ^ ofs_i[11];
            default: begin
                flip  = 1'b0;
                bad_o = 1'b1;
            end
        endcase
        ofs_o    = ofs_i;
        ofs_o[6] = ofs_i[6] ^ flip;
    end

    // Guard: only bit 6 may differ between input and output (R5).
    always_comb begin
        p_swz_keep_r5: assert (((ofs_o ^ ofs_i) & ~12'h040) == 12'h000);
    end

    // Guard: code 0 is the identity (R5).
    always_comb begin
        if (mode_i == 3'd0)
            p_swz_none_r5: assert (ofs_o == ofs_i);
    end
endmodule

// File: rtl/tag_addr_gen.sv
// Module: top of the tiled surface address generator.
// Picks the linear or one of two tiled offsets, applies the swizzle to
// the in-tile part, flags undefined codes, and optionally registers.
// Assumes: one coordinate per cycle; no backpressure.
module tag_addr_gen #(
    parameter int X_W     = 16,
    parameter int Y_W     = 16,
    parameter int PITCH_W = 16,
    parameter int BPP_W   = 3,
    parameter int OFS_W   = 32,
    parameter bit PIPE    = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [X_W-1:0]     x_in,
    input  logic [Y_W-1:0]     y_in,
    input  logic [PITCH_W-1:0] pitch_in,
    input  logic [BPP_W-1:0]   bpp_in,
    input  logic [1:0]         layout_in,
    input  logic [2:0]         swz_in,
    output logic               out_valid,
    output logic [OFS_W-1:0]   offset_out,
    output logic               err_out
);
    import tag_pkg::*;

    logic [OFS_W-1:0]     lin_ofs, wide_base, tall_base, sel_base;
    logic [TILE_LOG2-1:0] wide_in, tall_in, sel_in, swz_out;
    logic                 swz_bad, err_c;
    logic [OFS_W-1:0]     ofs_c;

    tag_linear #(.X_W(X_W), .Y_W(Y_W), .PITCH_W(PITCH_W), .BPP_W(BPP_W),
                 .OFS_W(OFS_W)) lin_i (
        .x_i(x_in), .y_i(y_in), .pitch_i(pitch_in), .bpp_i(bpp_in),
        .ofs_o(lin_ofs));

    tag_tile_geom #(.X_W(X_W), .Y_W(Y_W), .PITCH_W(PITCH_W), .BPP_W(BPP_W),
                    .OFS_W(OFS_W), .IS_TALL(1'b0)) wide_i (
        .x_i(x_in), .y_i(y_in), .pitch_i(pitch_in), .bpp_i(bpp_in),
        .intile_o(wide_in), .base_o(wide_base));

    tag_tile_geom #(.X_W(X_W), .Y_W(Y_W), .PITCH_W(PITCH_W), .BPP_W(BPP_W),
                    .OFS_W(OFS_W), .IS_TALL(1'b1)) tall_i (
        .x_i(x_in), .y_i(y_in), .pitch_i(pitch_in), .bpp_i(bpp_in),
        .intile_o(tall_in), .base_o(tall_base));

    // Choose the tile geometry that feeds the shared swizzle stage.
    always_comb begin
        sel_in   = (layout_in == LAYOUT_TALL) ? tall_in : wide_in;
        sel_base = (layout_in == LAYOUT_TALL) ? tall_base : wide_base;
    end

    tag_swizzle swz_i (
        .ofs_i(sel_in), .mode_i(swz_in), .ofs_o(swz_out), .bad_o(swz_bad));

    // Final offset; undefined codes force zero with the error flag.
    always_comb begin
        err_c = swz_bad || (layout_in == 2'd3);
        if (err_c)
            ofs_c = '0;
        else if (layout_in == LAYOUT_LINEAR)
            ofs_c = lin_ofs;
        else
            ofs_c = sel_base + OFS_W'(swz_out);
    end

    generate
        if (PIPE) begin : g_reg
            // Output register stage with valid; data loads only on valid.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_valid  <= 1'b0;
                    offset_out <= '0;
                    err_out    <= 1'b0;
                end else begin
                    out_valid <= in_valid;
                    if (in_valid) begin
                        offset_out <= ofs_c;
                        err_out    <= err_c;
                    end
                end
            end

            // Guard: valid input appears at the output one cycle later (R8).
            p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);
            // Guard: idle input gives idle output next cycle (R8).
            p_idle_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);
        end else begin : g_comb
            // Pass-through: result in the same cycle.
            always_comb begin
                out_valid  = in_valid;
                offset_out = ofs_c;
                err_out    = err_c;
            end
        end
    endgenerate

    // Guard: an error never comes with a partial offset (R7).
    p_err_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_out |-> (offset_out == '0));
endmodule

// File: tb/tag_addr_gen_tb_top.sv
// Bench: sweeps coordinates, bytes per pixel, layouts and swizzle codes,
// computing the expected offset arithmetically from the requirements.
module tag_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] x_in = '0, y_in = '0, pitch_in = '0;
    logic [2:0]  bpp_in = '0;
    logic [1:0]  layout_in = '0;
    logic [2:0]  swz_in = '0;
    logic        out_valid;
    logic [31:0] offset_out;
    logic        err_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;   // 100 MHz

    tag_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .x_in(x_in), .y_in(y_in), .pitch_in(pitch_in), .bpp_in(bpp_in),
        .layout_in(layout_in), .swz_in(swz_in),
        .out_valid(out_valid), .offset_out(offset_out), .err_out(err_out));

    task automatic check(input bit ok, input string tag,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected offset from the requirement formulas.
    function automatic longint expect_ofs(int x, int y, int p, int b,
                                          int lay, int sw, output bit err);
        int xb, intile, w, h, flip;
        err = (lay == 3) || (sw > 4);                 // R7
        if (err) return 0;
        if (lay == 0) return longint'((y * p + x) * b); // R1, R6
        xb = x * b;
        if (lay == 1) begin                           // R2
            w = 512; h = 8;
            intile = (y % 8) * 512 + (xb % 512);
        end else begin                                // R3
            w = 128; h = 32;
            intile = ((xb % 128) / 16) * 512 + (y % 32) * 16 + (xb % 16);
        end
        flip = 0;                                     // R5
        if (sw != 0) flip = (intile >> 9) & 1;
        if (sw == 2 || sw == 4) flip ^= (intile >> 10) & 1;
        if (sw == 3 || sw == 4) flip ^= (intile >> 11) & 1;
        intile ^= flip << 6;
        // R4: tile base
        return longint'((xb / w) * 4096 + (y / h) * p * b * h + intile);
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        bit    e_err;
        longint e_ofs;
        string tag;
        int    bpps[3] = '{1, 2, 4};
        repeat (3) @(negedge clk);
        // R8: reset state
        check(out_valid == 1'b0, "R8 reset valid", out_valid, 0);
        check(offset_out == 0, "R8 reset offset", offset_out, 0);
        check(err_out == 1'b0, "R8 reset err", err_out, 0);
        rst_n = 1'b1;
        pitch_in = 16'd320;
        for (int bi = 0; bi < 3; bi++) begin
            for (int lay = 0; lay < 4; lay++) begin
                for (int sw = 0; sw < 8; sw++) begin
                    for (int x = 0; x <= 200; x += 7) begin
                        for (int y = 0; y < 68; y += 4) begin
                            @(negedge clk);
                            in_valid = 1'b1;
                            x_in = 16'(x); y_in = 16'(y);
                            bpp_in = 3'(bpps[bi]);
                            layout_in = 2'(lay); swz_in = 3'(sw);
                            e_ofs = expect_ofs(x, y, 320, bpps[bi], lay, sw, e_err);
                            @(negedge clk);
                            in_valid = 1'b0;
                            if (e_err) tag = "R7";
                            else if (lay == 0) tag = (sw == 0) ? "R1" : "R6";
                            else if (sw != 0) tag = "R5";
                            else if (y >= (lay == 1 ? 8 : 32) ||
                                     x * bpps[bi] >= (lay == 1 ? 512 : 128)) tag = "R4";
                            else tag = (lay == 1) ? "R2" : "R3";
                            check(offset_out == 32'(e_ofs), tag, offset_out, e_ofs);
                            check(err_out == e_err, {tag, " err"}, err_out, e_err);
                            check(out_valid == 1'b1, "R8 valid", out_valid, 1);
                        end
                    end
                end
            end
        end
        // R8: idle cycle gives out_valid low, data held
        @(negedge clk);
        check(out_valid == 1'b0, "R8 idle", out_valid, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule